// File: doc/BRIEF.md
# Real-Time-Clock Prescaler and Minute Divider

This block turns a 32.768 kHz oscillator-domain clock into the slow timing signals of a real-time clock. One binary counter divides the input down to a 1 Hz square wave, and one of its lower stages is brought out as a 128 Hz square wave for trimming the crystal. A second counter counts the falling edges of the seconds wave and derives a square wave with a one-minute period.

Each falling edge of the minute wave is the event that steps the downstream time counter. For that purpose the block raises a one-cycle advance strobe in the same cycle that the minute wave drops. A fixed number of input cycles later, about 4 ms, it raises a second one-cycle strobe that tells an alarm comparator when to sample.

An asynchronous reset and a synchronous clear both bring every stage back to zero. The seconds and minute waves are also gathered into a two-bit status word for readback.

Top module: `rtc_prescaler`

## Requirements
- R1: While `arst_n` is low, every output is 0, regardless of the clock.
- R2: A cycle with `sync_clr` high returns every stage to its reset state at that clock edge. This includes a pending compare strobe, which is then never issued. Timing then restarts as if reset had just been released.
- R3: After reset, `sec_out` stays low for SEC_HALF cycles, then high for SEC_HALF cycles, and repeats with a 1:1 ratio.
- R4: `cal_out` is a 1:1 square wave of period 2*CAL_HALF cycles that starts low after reset. It comes from the same counter as `sec_out`, so 2*SEC_HALF/(2*CAL_HALF) of its periods fit in each seconds period.
- R5: `min_out` toggles on every MIN_SECS-th falling edge of `sec_out`, counted from reset. It starts low and has a 1:1 ratio, so its period is 2*MIN_SECS seconds.
- R6: `min_out` changes state only in the cycle in which `sec_out` goes from high to low.
- R7: `min_adv` is high for exactly one cycle, and it is high exactly in the cycle in which `min_out` goes from high to low.
- R8: `cmp_strobe` is high for exactly one cycle, CMP_DELAY cycles after each `min_adv` cycle.
- R9: `status[0]` equals `sec_out` and `status[1]` equals `min_out` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock (32.768 kHz nominal) |
| arst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous clear of the whole divider chain |
| cal_out | output | 1 | 128 Hz square wave for oscillator trimming |
| sec_out | output | 1 | 1 Hz square wave |
| min_out | output | 1 | One-minute square wave |
| min_adv | output | 1 | One-cycle strobe on the falling edge of `min_out` |
| cmp_strobe | output | 1 | One-cycle strobe CMP_DELAY cycles after `min_adv` |
| status | output | 2 | Readback: bit 1 = minute wave, bit 0 = seconds wave |

## Verification
The bench builds the block with SEC_HALF=8, CAL_HALF=2, MIN_SECS=3 and CMP_DELAY=5. With these values a full minute period takes 96 cycles, so several minute edges and compare strobes fit into a few hundred cycles. Every output is checked in every cycle against a closed-form model indexed by the cycle count since reset. The short delay also leaves room to issue a synchronous clear between an advance strobe and its compare strobe, and to assert the asynchronous reset part way through a seconds period.

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int SEC_HALF  = 16384,
  parameter int CAL_HALF  = 128,
  parameter int MIN_SECS  = 30,
  parameter int CMP_DELAY = 131
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       sync_clr,
  output logic       cal_out,
  output logic       sec_out,
  output logic       min_out,
  output logic       min_adv,
  output logic       cmp_strobe,
  output logic [1:0] status
);

  localparam int HC_W   = $clog2(SEC_HALF);
  localparam int CAL_B  = $clog2(CAL_HALF);
  localparam int SC_W   = $clog2(MIN_SECS + 1);
  localparam int DLY_W  = $clog2(CMP_DELAY + 1);
  localparam logic [HC_W-1:0]  HC_LAST = HC_W'(SEC_HALF - 1);
  localparam logic [SC_W-1:0]  SC_LAST = SC_W'(MIN_SECS - 1);
  localparam logic [DLY_W-1:0] DLY_LD  = DLY_W'(CMP_DELAY);

  logic [HC_W-1:0]  hc_q;
  logic [SC_W-1:0]  sc_q;
  logic [DLY_W-1:0] dly_q;
  logic             sec_q, min_q, adv_q, cmp_q;

  logic hc_wrap, sec_fall, sc_wrap, min_fall;

  assign hc_wrap  = (hc_q == HC_LAST);
  assign sec_fall = hc_wrap && sec_q;
  assign sc_wrap  = (sc_q == SC_LAST);
  assign min_fall = sec_fall && sc_wrap && min_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hc_q <= '0;
      sec_q <= 1'b0;
    end else if (sync_clr) begin
      hc_q <= '0;
      sec_q <= 1'b0;
    end else begin
      hc_q <= hc_wrap ? '0 : hc_q + 1'b1;
      if (hc_wrap) sec_q <= ~sec_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sc_q <= '0;
      min_q <= 1'b0;
    end else if (sync_clr) begin
      sc_q <= '0;
      min_q <= 1'b0;
    end else if (sec_fall) begin
      sc_q <= sc_wrap ? '0 : sc_q + 1'b1;
      if (sc_wrap) min_q <= ~min_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dly_q <= '0;
      adv_q <= 1'b0;
      cmp_q <= 1'b0;
    end else if (sync_clr) begin
      dly_q <= '0;
      adv_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      adv_q <= min_fall;
      cmp_q <= (dly_q == DLY_W'(1));
      if (min_fall)          dly_q <= DLY_LD;
      else if (dly_q != '0)  dly_q <= dly_q - 1'b1;
    end
  end

  assign cal_out    = hc_q[CAL_B];
  assign sec_out    = sec_q;
  assign min_out    = min_q;
  assign min_adv    = adv_q;
  assign cmp_strobe = cmp_q;
  assign status     = {min_q, sec_q};

  p_sec_count_range_r5: assert property (@(posedge clk) disable iff (!arst_n)
    sc_q < SC_W'(MIN_SECS));

  p_min_on_sec_fall_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (!$past(sync_clr) && (min_q != $past(min_q))) |-> (!sec_q && $past(sec_q)));

  p_adv_single_r7: assert property (@(posedge clk) disable iff (!arst_n)
    min_adv |=> !min_adv);

  p_adv_on_min_fall_r7: assert property (@(posedge clk) disable iff (!arst_n)
    min_adv |-> (!min_q && $past(min_q)));

  p_cmp_single_r8: assert property (@(posedge clk) disable iff (!arst_n)
    cmp_strobe |=> !cmp_strobe);

  p_cmp_not_with_adv_r8: assert property (@(posedge clk) disable iff (!arst_n)
    min_adv |-> !cmp_strobe);

endmodule

// File: tb/test_rtc_prescaler.sv
module test_rtc_prescaler;
  localparam int SH  = 8;
  localparam int CH  = 2;
  localparam int MS  = 3;
  localparam int DL  = 5;
  localparam int PER = 4 * SH * MS;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic sync_clr = 1'b0;
  logic cal_out, sec_out, min_out, min_adv, cmp_strobe;
  logic [1:0] status;

  int checks = 0;
  int fails = 0;
  logic prev_sec, prev_min;

  always #5 clk = ~clk;

  rtc_prescaler #(.SEC_HALF(SH), .CAL_HALF(CH), .MIN_SECS(MS), .CMP_DELAY(DL)) i_rtc_prescaler (
    .clk(clk), .arst_n(arst_n), .sync_clr(sync_clr), .cal_out(cal_out),
    .sec_out(sec_out), .min_out(min_out), .min_adv(min_adv),
    .cmp_strobe(cmp_strobe), .status(status));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_zero(input string req);
    check({cal_out, sec_out, min_out, min_adv, cmp_strobe, status} == 7'd0, req,
          int'({cal_out, sec_out, min_out, min_adv, cmp_strobe, status}), 0);
  endtask

  task automatic check_cycle(input int k);
    int e_sec, e_cal, e_min, e_adv, e_cmp;
    e_sec = (k / SH) % 2;
    e_cal = (k / CH) % 2;
    e_min = ((k / (2 * SH)) / MS) % 2;
    e_adv = (k > 0 && k % PER == 0) ? 1 : 0;
    e_cmp = (k > DL && (k - DL) % PER == 0) ? 1 : 0;
    check(int'(sec_out) == e_sec, "R3 sec_out", int'(sec_out), e_sec);
    check(int'(cal_out) == e_cal, "R4 cal_out", int'(cal_out), e_cal);
    check(int'(min_out) == e_min, "R5 min_out", int'(min_out), e_min);
    check(int'(min_adv) == e_adv, "R7 min_adv", int'(min_adv), e_adv);
    check(int'(cmp_strobe) == e_cmp, "R8 cmp_strobe", int'(cmp_strobe), e_cmp);
    check(status == {min_out, sec_out}, "R9 status", int'(status), int'({min_out, sec_out}));
    if (k > 0 && min_out != prev_min)
      check(prev_sec && !sec_out, "R6 min change without sec fall", int'(sec_out), 0);
    prev_sec = sec_out;
    prev_min = min_out;
  endtask

  task automatic run(input int from_k, input int to_k);
    for (int k = from_k; k <= to_k; k++) begin
      if (k > 0) @(negedge clk);
      check_cycle(k);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0;
    #1;
    check_zero("R1 outputs in reset");
    @(negedge clk);
    arst_n = 1'b1;
  endtask

  task automatic t_free_run();
    do_reset();
    run(0, 3 * PER + 10);
  endtask

  task automatic t_sync_clear();
    do_reset();
    run(0, PER + 2);
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
    check_zero("R2 state after sync_clr");
    run(0, PER + DL + 4);
  endtask

  task automatic t_async_mid();
    do_reset();
    run(0, 3 * SH / 2 + 1);
    arst_n = 1'b0;
    #1;
    check_zero("R1 async reset mid-run");
    @(posedge clk);
    #1;
    check_zero("R1 clock edge during reset");
    @(negedge clk);
    arst_n = 1'b1;
    run(0, PER + DL + 2);
  endtask

  initial begin
    #(50000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_free_run();
    t_sync_clear();
    t_async_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule